// File: doc/BRIEF.md
# Dual-Bank Receive Frame Store with Destination Filter

This block accepts Ethernet frames as a byte stream (valid, data, last) and stores each accepted frame in one of two equal receive banks. The first six bytes are checked against a station address. Group-addressed frames always pass the check. A frame goes into the bank that is currently active. Once stored, that bank is marked full, and the active bank moves to the other one when alternation is enabled.

Software reads stored bytes through a combinational read port. It frees a bank by writing its control word with the full bit at zero. A frame that reaches a full bank is lost. Frames that are too long or too short are discarded. Discarded frames never mark a bank full and never raise the interrupt. An optional one-cycle interrupt pulse reports each stored frame.

Top module: `pingpong_rx`

## Requirements
- R1: After reset the active bank is 0, both full bits and both interrupt-enable bits read 0, the global enable reads 0, and `irq` is low.
- R2: A frame passes the filter when bit 7 of its first byte is set, or when its bytes 0..5 equal `station_mac[47:40]`, `[39:32]`, ..., `[7:0]` in that order. Any other frame is discarded with no change to the full bits, the active bank or `irq`. Bytes after the sixth play no part in the decision.
- R3: A frame whose first byte arrives while the active bank's full bit is set is lost. It writes no byte of that bank and changes no full bit, no active bank and no `irq`.
- R4: A frame longer than `BUF_BYTES` bytes is discarded, and so is one shorter than 6 bytes. A frame of exactly `BUF_BYTES` bytes is stored.
- R5: A stored frame's byte k is readable at address k of the bank that was active when it arrived. That bank's full bit (bit 0 of its control word) reads 1 from the cycle after the last byte.
- R6: `irq` is high for exactly the one cycle after a frame is stored. This happens only if the global enable (register 2, bit 31) and bank 0's interrupt enable (register 0, bit 3) are both set, whichever bank took the frame.
- R7: After each stored frame, the active bank flips when `pingpong_en` is 1 and becomes bank 0 when it is 0.
- R8: Registers 0 and 1 are the control words of banks 0 and 1. A write with bit 0 at 0 clears that bank's full bit, and a write with bit 0 at 1 leaves it unchanged. Bit 3 is stored as the interrupt enable. A store in the same cycle as a clear of the same bank leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming byte is valid |
| in_data | input | 8 | Incoming frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| pingpong_en | input | 1 | Alternate banks after each stored frame |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 bank-0 control, 1 bank-1 control, 2 global |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd_buf | input | 1 | Bank selected for reading |
| mem_rd_addr | input | AW | Byte address within the bank |
| mem_rd_data | output | 8 | Stored byte (combinational) |
| active_buf | output | 1 | Bank the next frame goes to |
| irq | output | 1 | One-cycle pulse per stored frame |

## Verification
Three results follow the clock edge that samples a frame's last byte: the full bit, the new active bank and the interrupt pulse. All three are due one cycle after that edge. Register writes take effect at the next edge, and reads of registers and bank bytes are combinational. The bench drives every input on the falling edge. It checks one full falling edge after the last byte, by which point the pulse has been counted by a monitor at the rising edge in between. Expected bank contents, full bits and pulse counts come from an arithmetic model in the bench that follows R2 to R8.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    localparam int MAC_BYTES = 6;
    localparam int BIT_FULL  = 0;
    localparam int BIT_IE    = 3;
    localparam int BIT_GIE   = 31;

    typedef enum logic [1:0] {
        REG_CTL0   = 2'd0,
        REG_CTL1   = 2'd1,
        REG_GLOBAL = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ie;
        logic full;
    } bank_ctl_t;

    // Byte i of the station address; byte 0 sits in the top bits.
    function automatic logic [7:0] addr_byte(input logic [47:0] mac, input logic [2:0] i);
        logic [47:0] shifted;
        shifted = mac << {i, 3'b000};
        return shifted[47:40];
    endfunction

    function automatic logic is_group(input logic [7:0] first_byte);
        return first_byte[7];
    endfunction

    function automatic logic [31:0] ctl_word(input bank_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[BIT_FULL] = c.full;
        w[BIT_IE]   = c.ie;
        return w;
    endfunction

endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
    import rxpp_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          first,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    data,
    input  logic [47:0]   mac,
    output logic          pass
);
    logic grp_q, match_q;
    logic grp_now, match_now, in_hdr;

    always_comb begin
        in_hdr    = idx < IW'(MAC_BYTES);
        grp_now   = first ? is_group(data) : grp_q;
        match_now = (first ? 1'b1 : match_q)
                    && (!in_hdr || data == addr_byte(mac, idx[2:0]));
        pass      = grp_now || match_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q   <= 1'b0;
            match_q <= 1'b0;
        end else if (valid) begin
            grp_q   <= grp_now;
            match_q <= match_now;
        end
    end
endmodule

// File: rtl/rxpp_frame_ctrl.sv
module rxpp_frame_ctrl
    import rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int IW        = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          cur_full,
    input  logic          pass,
    output logic          first,
    output logic [IW-1:0] idx,
    output logic          mem_we,
    output logic          commit
);
    logic          in_frame_q, lost_q;
    logic [IW-1:0] cnt_q;
    logic          lost_now, fits;

    always_comb begin
        first    = in_valid && !in_frame_q;
        idx      = first ? '0 : cnt_q;
        lost_now = first ? cur_full : lost_q;
        fits     = idx < IW'(BUF_BYTES);
        mem_we   = in_valid && !lost_now && fits;
        commit   = in_valid && in_last && !lost_now && fits
                   && (idx >= IW'(MAC_BYTES - 1)) && pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            lost_q     <= 1'b0;
            cnt_q      <= '0;
        end else if (in_valid) begin
            in_frame_q <= !in_last;
            lost_q     <= lost_now;
            cnt_q      <= fits ? idx + 1'b1 : idx;
        end
    end

    // R4: a byte beyond the bank never reaches the store
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_frame_q && cnt_q >= IW'(BUF_BYTES)) |-> !mem_we && !commit);
endmodule

// File: rtl/rxpp_buf_mem.sv
module rxpp_buf_mem #(
    parameter int BUF_BYTES = 64,
    parameter int AW        = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wsel,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rsel,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] store [BUF_BYTES];
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(b))) store[waddr] <= wdata;
        end
        assign bank_rd[b] = store[raddr];
    end

    assign rdata = bank_rd[rsel];
endmodule

// File: rtl/pingpong_rx.sv
module pingpong_rx
    import rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int IW = $clog2(BUF_BYTES + 1),
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [47:0]   station_mac,
    input  logic          pingpong_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          mem_rd_buf,
    input  logic [AW-1:0] mem_rd_addr,
    output logic [7:0]    mem_rd_data,
    output logic          active_buf,
    output logic          irq
);
    bank_ctl_t     ctl_q [2];
    logic          gie_q, active_q, irq_q;
    logic          first, pass, mem_we, commit, cur_full;
    logic [IW-1:0] idx;
    logic          unused_wdata_bits;

    assign unused_wdata_bits = ^{reg_wdata[30:4], reg_wdata[2:1]};
    assign cur_full = ctl_q[active_q].full;

    rxpp_addr_filter #(.IW(IW)) i_filter (
        .clk(clk), .rst(rst), .valid(in_valid), .first(first), .idx(idx),
        .data(in_data), .mac(station_mac), .pass(pass)
    );

    rxpp_frame_ctrl #(.BUF_BYTES(BUF_BYTES), .IW(IW)) i_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .cur_full(cur_full), .pass(pass), .first(first), .idx(idx),
        .mem_we(mem_we), .commit(commit)
    );

    rxpp_buf_mem #(.BUF_BYTES(BUF_BYTES), .AW(AW)) i_mem (
        .clk(clk), .we(mem_we), .wsel(active_q), .waddr(idx[AW-1:0]),
        .wdata(in_data), .rsel(mem_rd_buf), .raddr(mem_rd_addr),
        .rdata(mem_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q[0] <= '0;
            ctl_q[1] <= '0;
            gie_q    <= 1'b0;
            active_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_sel_e'(reg_addr))
                    REG_CTL0: begin
                        ctl_q[0].ie <= reg_wdata[BIT_IE];
                        if (!reg_wdata[BIT_FULL]) ctl_q[0].full <= 1'b0;
                    end
                    REG_CTL1: begin
                        ctl_q[1].ie <= reg_wdata[BIT_IE];
                        if (!reg_wdata[BIT_FULL]) ctl_q[1].full <= 1'b0;
                    end
                    REG_GLOBAL: gie_q <= reg_wdata[BIT_GIE];
                    default: ;
                endcase
            end
            if (commit) begin
                ctl_q[active_q].full <= 1'b1;
                active_q <= pingpong_en ? ~active_q : 1'b0;
            end
            irq_q <= commit && gie_q && ctl_q[0].ie;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_CTL0:   reg_rdata = ctl_word(ctl_q[0]);
            REG_CTL1:   reg_rdata = ctl_word(ctl_q[1]);
            REG_GLOBAL: reg_rdata = {gie_q, 31'b0};
            default:    reg_rdata = '0;
        endcase
    end

    assign active_buf = active_q;
    assign irq        = irq_q;

    // R3: a store never lands in a bank that is already full
    assert_no_commit_to_full_R3: assert property (@(posedge clk) disable iff (rst)
        commit |-> !cur_full);
    // R5: the receiving bank reads full after the store
    assert_bank0_full_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && !active_q) |=> ctl_q[0].full);
    assert_bank1_full_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && active_q) |=> ctl_q[1].full);
    // R6: a pulse only follows an enabled store
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(commit && gie_q && ctl_q[0].ie));
    // R7: bank selection after a store
    assert_pp_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && pingpong_en) |=> active_q != $past(active_q));
    assert_pp_off_bank0_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && !pingpong_en) |=> !active_q);
endmodule

// File: tb/test_pingpong_rx.sv
module test_pingpong_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BUF = 16;
    localparam int AW = $clog2(BUF);
    localparam logic [47:0] MAC = 48'h02_1a_2b_3c_4d_5e;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_last = 0;
    logic [7:0] in_data = 0;
    logic pingpong_en = 1;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_rd_buf = 0;
    logic [AW-1:0] mem_rd_addr = 0;
    logic [7:0] mem_rd_data;
    logic active_buf, irq;

    int checks = 0, errors = 0;
    int irq_seen = 0, irq_exp = 0;
    logic [7:0] fr [32];
    logic [7:0] exp_mem [2][BUF];
    int exp_len [2];
    logic full_m [2];
    logic act_m = 0, gie_m = 0, ie0_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pingpong_rx #(.BUF_BYTES(BUF)) i_pingpong_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .station_mac(MAC), .pingpong_en(pingpong_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_rd_buf(mem_rd_buf),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .active_buf(active_buf), .irq(irq)
    );

    always @(posedge clk) if (!rst && irq) irq_seen++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 2'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rreg(int a, output logic [31:0] d);
        reg_addr = 2'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_bank(int b);
        wreg(b, (b == 0 && ie0_m) ? 32'h8 : 32'h0);
        full_m[b] = 0;
    endtask

    // kind 0: unicast to station (badpos corrupts one header byte), kind 1: group
    task automatic build(int len, int kind, int badpos, int seed);
        for (int i = 0; i < len; i++) begin
            if (i < 6) begin
                if (kind == 1) fr[i] = (i == 0) ? 8'h85 : 8'hff;
                else fr[i] = MAC[47-8*i -: 8] ^ ((i == badpos) ? 8'h10 : 8'h00);
            end else fr[i] = 8'(seed + i * 13);
        end
    endtask

    task automatic drive(int len, bit clear_at_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = fr[i]; in_last = (i == len - 1);
            if (clear_at_last && i == len - 1) begin
                reg_we = 1; reg_addr = 2'(act_m);
                reg_wdata = (act_m == 0 && ie0_m) ? 32'h8 : 32'h0;
            end
        end
        @(negedge clk);
        in_valid = 0; in_last = 0; reg_we = 0;
        @(negedge clk);
    endtask

    task automatic model(int len, bit filt);
        bit acc;
        acc = !full_m[act_m] && len >= 6 && len <= BUF && filt;
        if (acc) begin
            for (int i = 0; i < len; i++) exp_mem[act_m][i] = fr[i];
            exp_len[act_m] = len;
            full_m[act_m] = 1;
            if (gie_m && ie0_m) irq_exp++;
            act_m = pingpong_en ? ~act_m : 1'b0;
        end
    endtask

    task automatic verify(string req);
        logic [31:0] d;
        chk({req, " active bank"}, 32'(active_buf), 32'(act_m));
        rreg(0, d); chk({req, " bank0 full"}, 32'(d[0]), 32'(full_m[0]));
        rreg(1, d); chk({req, " bank1 full"}, 32'(d[0]), 32'(full_m[1]));
        chk({req, " irq count"}, 32'(irq_seen), 32'(irq_exp));
        for (int b = 0; b < 2; b++) begin
            if (full_m[b]) begin
                for (int i = 0; i < exp_len[b]; i++) begin
                    mem_rd_buf = 1'(b); mem_rd_addr = AW'(i);
                    #1;
                    chk({req, " stored byte"}, 32'(mem_rd_data), 32'(exp_mem[b][i]));
                end
            end
        end
    endtask

    task automatic frame(int len, int kind, int badpos, int seed, string req);
        build(len, kind, badpos, seed);
        drive(len, 0);
        model(len, kind == 1 || badpos < 0 || badpos >= 6);
        verify(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        full_m[0] = 0; full_m[1] = 0; exp_len[0] = 0; exp_len[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 active", 32'(active_buf), 0);
        chk("R1 irq", 32'(irq), 0);
        rreg(0, d); chk("R1 ctl0", d, 0);
        rreg(1, d); chk("R1 ctl1", d, 0);
        rreg(2, d); chk("R1 global", d, 0);

        wreg(2, 32'h8000_0000); gie_m = 1;
        wreg(0, 32'h8); ie0_m = 1;
        rreg(2, d); chk("R8 global readback", d, 32'h8000_0000);
        rreg(0, d); chk("R8 ie readback", d, 32'h8);

        frame(8, 0, -1, 3, "R5 R2 unicast store");
        frame(10, 1, -1, 5, "R6 R7 group store to bank1");
        frame(8, 0, -1, 9, "R3 lost on full bank");
        frame(12, 1, -1, 11, "R3 lost group frame");

        wreg(0, 32'h9);
        verify("R8 write one keeps full");
        clear_bank(0);
        verify("R8 clear bank0");
        clear_bank(1);
        verify("R8 clear bank1");

        // R2: corrupt each header byte, also vary payload
        for (int p = 0; p < 6; p++) frame(9, 0, p, p * 17, "R2 mismatch dropped");
        frame(9, 0, 7, 1, "R2 payload ignored by filter");

        // R4: length sweep
        for (int len = 1; len <= 20; len++) begin
            clear_bank(0); clear_bank(1);
            frame(len, 0, -1, len, "R4 length sweep");
        end
        for (int len = 1; len <= 20; len++) begin
            clear_bank(0); clear_bank(1);
            frame(len, 1, -1, len + 40, "R4 group length sweep");
        end

        // R6: interrupt gating
        clear_bank(0); clear_bank(1);
        wreg(2, 0); gie_m = 0;
        frame(8, 0, -1, 21, "R6 no irq without global enable");
        wreg(2, 32'h8000_0000); gie_m = 1;
        ie0_m = 0; clear_bank(0); clear_bank(1);
        frame(8, 0, -1, 22, "R6 no irq without bank0 enable");
        ie0_m = 1; clear_bank(0); clear_bank(1);
        frame(8, 0, -1, 23, "R6 irq restored");

        // R7: alternation off
        pingpong_en = 0;
        for (int k = 0; k < 3; k++) begin
            clear_bank(0); clear_bank(1);
            frame(7, 0, -1, 30 + k, "R7 alternation off");
        end
        pingpong_en = 1;

        // R8: store and clear in the same cycle
        clear_bank(0); clear_bank(1);
        build(8, 0, -1, 50);
        drive(8, 1);
        model(8, 1);
        verify("R8 store wins over clear");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule